// File: doc/BRIEF.md
# State-Retention Test Sequencer

This controller sits in the always-on part of a chip and, while test mode is active, takes a switchable power domain away from its functional power controller. It then cycles that domain through a real power-down and power-up between a scan load and a scan unload. The purpose is to show that the domain's retention flops keep their contents across the outage. A forced-on structural test cannot show this, because the domain never actually loses power during it.

A one-cycle start pulse begins a run. The controller first asks the surrounding scan logic to load a value and keeps a copy of what was loaded. It then saves retention state and, when the domain drives a neighbour that stays powered, raises isolation. Next it removes power and restores it, waiting for the domain's power-good acknowledge. After that it drops isolation, restores retention and asks the scan logic to unload. The unloaded value is compared with the stored copy. Each timed step lasts a programmable number of cycles. A parameter selects whether retention is driven as one held level or as separate one-cycle save and restore pulses.

When test mode is low, or while no run is active, every domain control output simply follows the matching functional input.

Top module: `rtn_test_seq`

## Requirements
- R1: With `test_mode` low, each of `ret_save`, `ret_restore`, `iso_en`, `pwr_on` and `scan_en` equals its `func_*` input in the same cycle, `shift_req` is 0, and `start` is ignored (`busy` stays 0).
- R2: While `busy` is high in test mode, the five domain controls come from the sequencer and do not follow the `func_*` inputs.
- R3: A run passes through these steps in order: load (`scan_en`=1, `shift_out`=0), save, isolation on, power off (`pwr_on`=0), power on, isolation off, restore, unload (`scan_en`=1, `shift_out`=1). During both scan steps `pwr_on`=1 and `iso_en`=0.
- R4: The two isolation steps are present only when `iso_needed` was high at start. When it was low, `iso_en` stays 0 for the whole run.
- R5: The save, isolation-on, power-off, isolation-off and restore steps each last exactly `dwell`+1 cycles. Each scan step ends in the cycle after `shift_done` is seen.
- R6: Isolation, when used, stays high from before power-off until after power-good has been seen in the power-on step.
- R7: The power-on step ends once `pwr_good` is high and at least `dwell` cycles have elapsed in the step. If `pwr_good` is still low after TIMEOUT+1 cycles in the step, `timeout_err` is set and the run ends without `done`. `fail` and `timeout_err` are never high together.
- R8: With RET_PULSE=0, `ret_save` is held high from the save step through the isolation-off step, and its fall is the restore; `ret_restore` stays 0. With RET_PULSE=1, `ret_save` is a single one-cycle pulse at the start of the save step and `ret_restore` is a single one-cycle pulse at the start of the restore step.
- R9: At the end of the unload, `done` is set. `fail` is set if `scan_out_data` differs from the `scan_in_data` captured at the end of the load. The run then returns to idle, so the controls follow the functional inputs again.
- R10: `start` in test mode while idle begins a run and clears `done`, `fail` and `timeout_err`. `start` during a run has no effect.
- R11: Dropping `test_mode` during a run returns the block to idle on the next clock. The controls follow the functional inputs at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 1 | Enables the override path |
| start | input | 1 | One-cycle pulse that starts a run |
| iso_needed | input | 1 | Domain feeds a neighbour that stays powered |
| dwell | input | CNT_W | Extra cycles per timed step |
| func_ret_save | input | 1 | Functional retention save/level |
| func_ret_restore | input | 1 | Functional retention restore |
| func_iso_en | input | 1 | Functional isolation enable |
| func_pwr_on | input | 1 | Functional power-switch request |
| func_scan_en | input | 1 | Functional scan enable |
| pwr_good | input | 1 | Power-good acknowledge from the domain |
| shift_done | input | 1 | Scan logic finished the requested shift |
| scan_in_data | input | DATA_W | Value loaded by the scan logic |
| scan_out_data | input | DATA_W | Value unloaded by the scan logic |
| ret_save | output | 1 | Retention save pulse or held level |
| ret_restore | output | 1 | Retention restore pulse |
| iso_en | output | 1 | Isolation enable to domain boundary |
| pwr_on | output | 1 | Power-switch request |
| scan_en | output | 1 | Scan enable to the domain |
| shift_req | output | 1 | Request to the scan logic to shift |
| shift_out | output | 1 | Shift direction: 1 for unload |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run reached the compare |
| fail | output | 1 | Last compare mismatched |
| timeout_err | output | 1 | Last run missed power-good |

## Verification
The properties assume that `iso_needed` and `dwell` stay constant while a run is active. They also assume that `pwr_good` is only high while the domain is being powered, and that `shift_done` only arrives while `shift_req` is high. The bench drives each run through a behavioural domain model that follows these rules. That model has a power-good delay, a fixed shift latency, retention shadow flops, corruption on power-off and an optional injected retention fault. The bench changes the configuration inputs only between runs.

// File: rtl/rtn_pkg.sv
package rtn_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SAVE,
        ST_ISO_ON,
        ST_OFF,
        ST_ON,
        ST_ISO_OFF,
        ST_RESTORE,
        ST_UNLOAD
    } seq_state_e;

    // Domain controls, in the order shared by functional and test paths.
    typedef struct packed {
        logic ret_save;
        logic ret_restore;
        logic iso_en;
        logic pwr_on;
        logic scan_en;
    } dom_ctl_t;

endpackage

// File: rtl/rtn_ovr_mux.sv
module rtn_ovr_mux #(
    parameter int N = 5
) (
    input  logic         sel,
    input  logic [N-1:0] func_i,
    input  logic [N-1:0] seq_i,
    output logic [N-1:0] ctl_o
);

    for (genvar gi = 0; gi < N; gi++) begin : g_bit
        always_comb begin
            ctl_o[gi] = sel ? seq_i[gi] : func_i[gi];
        end
    end

endmodule

// File: rtl/rtn_seq_fsm.sv
module rtn_seq_fsm
    import rtn_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 8,
    parameter int TIMEOUT   = 1000,
    parameter bit RET_PULSE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode,
    input  logic              start,
    input  logic              iso_needed,
    input  logic [CNT_W-1:0]  dwell,
    input  logic              pwr_good,
    input  logic              shift_done,
    input  logic [DATA_W-1:0] scan_in_data,
    input  logic [DATA_W-1:0] scan_out_data,
    output dom_ctl_t          seq_ctl,
    output logic              shift_req,
    output logic              shift_out,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              timeout_err
);

    localparam int TO_W = $clog2(TIMEOUT + 1);
    localparam int CW   = (CNT_W > TO_W) ? CNT_W : TO_W;
    localparam logic [CW-1:0] TO_LIM = CW'(TIMEOUT);

    typedef struct packed {
        seq_state_e        state;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] pat;
        logic              iso;
        logic              done;
        logic              fail;
        logic              tmo;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic [CW-1:0] dwell_ext;
    logic          step_ok;
    logic          lvl;

    always_comb begin
        dwell_ext = CW'(dwell);
        step_ok   = (r_q.cnt >= dwell_ext);
        lvl       = !RET_PULSE;
    end

    // Next-state computation.
    always_comb begin
        r_d     = r_q;
        r_d.cnt = (r_q.cnt == '1) ? r_q.cnt : r_q.cnt + 1'b1;
        unique case (r_q.state)
            ST_IDLE: begin
                if (test_mode && start) begin
                    r_d.state = ST_LOAD;
                    r_d.iso   = iso_needed;
                    r_d.done  = 1'b0;
                    r_d.fail  = 1'b0;
                    r_d.tmo   = 1'b0;
                end
            end
            ST_LOAD: begin
                if (shift_done) begin
                    r_d.pat   = scan_in_data;
                    r_d.state = ST_SAVE;
                end
            end
            ST_SAVE: begin
                if (step_ok) r_d.state = r_q.iso ? ST_ISO_ON : ST_OFF;
            end
            ST_ISO_ON: begin
                if (step_ok) r_d.state = ST_OFF;
            end
            ST_OFF: begin
                if (step_ok) r_d.state = ST_ON;
            end
            ST_ON: begin
                if (pwr_good && step_ok) begin
                    r_d.state = r_q.iso ? ST_ISO_OFF : ST_RESTORE;
                end else if (!pwr_good && (r_q.cnt >= TO_LIM)) begin
                    r_d.state = ST_IDLE;
                    r_d.tmo   = 1'b1;
                end
            end
            ST_ISO_OFF: begin
                if (step_ok) r_d.state = ST_RESTORE;
            end
            ST_RESTORE: begin
                if (step_ok) r_d.state = ST_UNLOAD;
            end
            ST_UNLOAD: begin
                if (shift_done) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.fail  = (scan_out_data != r_q.pat);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        if (!test_mode) r_d.state = ST_IDLE;
        if (r_d.state != r_q.state) r_d.cnt = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, pat: '0, iso: 1'b0,
                     done: 1'b0, fail: 1'b0, tmo: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    // Control values driven by each step.
    always_comb begin
        seq_ctl        = '0;
        seq_ctl.pwr_on = 1'b1;
        shift_req      = 1'b0;
        shift_out      = 1'b0;
        unique case (r_q.state)
            ST_LOAD: begin
                seq_ctl.scan_en = 1'b1;
                shift_req       = 1'b1;
            end
            ST_SAVE: begin
                seq_ctl.ret_save = lvl || (r_q.cnt == '0);
            end
            ST_ISO_ON: begin
                seq_ctl.ret_save = lvl;
                seq_ctl.iso_en   = 1'b1;
            end
            ST_OFF: begin
                seq_ctl.ret_save = lvl;
                seq_ctl.iso_en   = r_q.iso;
                seq_ctl.pwr_on   = 1'b0;
            end
            ST_ON: begin
                seq_ctl.ret_save = lvl;
                seq_ctl.iso_en   = r_q.iso;
            end
            ST_ISO_OFF: begin
                seq_ctl.ret_save = lvl;
            end
            ST_RESTORE: begin
                seq_ctl.ret_restore = !lvl && (r_q.cnt == '0);
            end
            ST_UNLOAD: begin
                seq_ctl.scan_en = 1'b1;
                shift_req       = 1'b1;
                shift_out       = 1'b1;
            end
            default: ;
        endcase
    end

    always_comb begin
        busy        = (r_q.state != ST_IDLE);
        done        = r_q.done;
        fail        = r_q.fail;
        timeout_err = r_q.tmo;
    end

endmodule

// File: rtl/rtn_test_seq.sv
module rtn_test_seq
    import rtn_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 8,
    parameter int TIMEOUT   = 1000,
    parameter bit RET_PULSE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode,
    input  logic              start,
    input  logic              iso_needed,
    input  logic [CNT_W-1:0]  dwell,
    input  logic              func_ret_save,
    input  logic              func_ret_restore,
    input  logic              func_iso_en,
    input  logic              func_pwr_on,
    input  logic              func_scan_en,
    input  logic              pwr_good,
    input  logic              shift_done,
    input  logic [DATA_W-1:0] scan_in_data,
    input  logic [DATA_W-1:0] scan_out_data,
    output logic              ret_save,
    output logic              ret_restore,
    output logic              iso_en,
    output logic              pwr_on,
    output logic              scan_en,
    output logic              shift_req,
    output logic              shift_out,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              timeout_err
);

    localparam int NCTL = $bits(dom_ctl_t);

    dom_ctl_t seq_ctl;
    dom_ctl_t func_ctl;
    dom_ctl_t out_ctl;
    logic     ovr_sel;

    always_comb begin
        func_ctl.ret_save    = func_ret_save;
        func_ctl.ret_restore = func_ret_restore;
        func_ctl.iso_en      = func_iso_en;
        func_ctl.pwr_on      = func_pwr_on;
        func_ctl.scan_en     = func_scan_en;
        ovr_sel              = test_mode && busy;
    end

    rtn_seq_fsm #(
        .DATA_W   (DATA_W),
        .CNT_W    (CNT_W),
        .TIMEOUT  (TIMEOUT),
        .RET_PULSE(RET_PULSE)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .test_mode    (test_mode),
        .start        (start),
        .iso_needed   (iso_needed),
        .dwell        (dwell),
        .pwr_good     (pwr_good),
        .shift_done   (shift_done),
        .scan_in_data (scan_in_data),
        .scan_out_data(scan_out_data),
        .seq_ctl      (seq_ctl),
        .shift_req    (shift_req),
        .shift_out    (shift_out),
        .busy         (busy),
        .done         (done),
        .fail         (fail),
        .timeout_err  (timeout_err)
    );

    rtn_ovr_mux #(
        .N(NCTL)
    ) u_mux (
        .sel   (ovr_sel),
        .func_i(func_ctl),
        .seq_i (seq_ctl),
        .ctl_o (out_ctl)
    );

    always_comb begin
        ret_save    = out_ctl.ret_save;
        ret_restore = out_ctl.ret_restore;
        iso_en      = out_ctl.iso_en;
        pwr_on      = out_ctl.pwr_on;
        scan_en     = out_ctl.scan_en;
    end

endmodule

// File: rtl/rtn_test_seq_chk.sv
module rtn_test_seq_chk #(
    parameter bit RET_PULSE = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic test_mode,
    input logic start,
    input logic iso_needed,
    input logic pwr_good,
    input logic ret_save,
    input logic iso_en,
    input logic pwr_on,
    input logic scan_en,
    input logic busy,
    input logic fail,
    input logic timeout_err
);

    assert_scan_powered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && test_mode && scan_en |-> pwr_on && !iso_en);

    assert_iso_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && test_mode && !pwr_on |-> iso_en == iso_needed);

    assert_iso_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && test_mode && $past(busy) && $past(test_mode) && $fell(iso_en)
        |-> $past(pwr_good));

    assert_timeout_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> !busy && !$past(pwr_good) && $past(busy));

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(fail && timeout_err));

    assert_level_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (RET_PULSE == 1'b0) && busy && test_mode && !pwr_on |-> ret_save);

    assert_pulse_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (RET_PULSE == 1'b1) && busy && test_mode && ret_save
        |=> !ret_save || !test_mode);

    assert_fail_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> !busy);

    assert_start_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && test_mode && start |=> busy);

    assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> !busy);

endmodule

bind rtn_test_seq rtn_test_seq_chk #(.RET_PULSE(RET_PULSE)) u_chk (.*);

// File: tb/rtn_test_seq_tb.sv
`timescale 1ns/1ps

module rtn_domain_model #(
    parameter int DATA_W    = 8,
    parameter int PGD       = 3,
    parameter int SHL       = 2,
    parameter bit RET_PULSE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              ret_save,
    input  logic              ret_restore,
    input  logic              shift_req,
    input  logic              shift_out,
    input  logic              pg_block,
    input  logic              ret_break,
    input  logic [DATA_W-1:0] pattern,
    output logic              pwr_good,
    output logic              shift_done,
    output logic [DATA_W-1:0] scan_in_data,
    output logic [DATA_W-1:0] scan_out_data
);
    logic [DATA_W-1:0] core, shadow;
    logic [7:0] pgc, sc;
    logic pwr_prev, save_prev;
    logic do_save, do_restore;

    always_comb begin
        pwr_good      = pwr_on && !pg_block && (pgc == 8'(PGD));
        shift_done    = shift_req && (sc == 8'(SHL));
        scan_in_data  = pattern;
        scan_out_data = core;
        do_save    = RET_PULSE ? ret_save : (ret_save && !save_prev);
        do_restore = RET_PULSE ? ret_restore : (save_prev && !ret_save && pwr_on);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core <= '0; shadow <= '0; pgc <= '0; sc <= '0;
            pwr_prev <= 1'b0; save_prev <= 1'b0;
        end else begin
            pgc <= !pwr_on ? 8'd0 : ((pgc == 8'(PGD)) ? pgc : pgc + 8'd1);
            sc  <= !shift_req ? 8'd0 : ((sc == 8'(SHL)) ? sc : sc + 8'd1);
            pwr_prev  <= pwr_on;
            save_prev <= ret_save;
            if (do_save) shadow <= core;
            if (pwr_prev && !pwr_on) core <= ~core;
            else if (shift_done && !shift_out) core <= pattern;
            else if (do_restore) core <= shadow ^ DATA_W'(ret_break);
        end
    end
endmodule

module rtn_test_seq_tb;
    localparam int DW = 8, CW = 4, TO = 12, PGD = 3, SHL = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic test_mode = 1'b0, start = 1'b0, iso_needed = 1'b0;
    logic [CW-1:0] dwell = '0;
    logic [4:0] func = 5'b11100;   // {ret_save, ret_restore, iso_en, pwr_on, scan_en}
    logic pg_block = 1'b0, ret_break = 1'b0;
    logic [DW-1:0] pattern = '0;

    logic pwr_good, shift_done, ret_save, ret_restore, iso_en, pwr_on, scan_en;
    logic shift_req, shift_out, busy, done, fail, timeout_err;
    logic [DW-1:0] sin, sout;
    logic pwr_good_p, shift_done_p, ret_save_p, ret_restore_p, iso_en_p, pwr_on_p, scan_en_p;
    logic shift_req_p, shift_out_p, busy_p, done_p, fail_p, timeout_err_p;
    logic [DW-1:0] sin_p, sout_p;

    int checks = 0, errors = 0;
    int nt = 0, ne = 0, ps_cnt = 0, pr_cnt = 0;
    logic [5:0] tr_sig [32]; int tr_len [32];
    logic [5:0] ex_sig [16]; int ex_len [16];

    always #10 clk = ~clk;

    rtn_test_seq #(.DATA_W(DW), .CNT_W(CW), .TIMEOUT(TO), .RET_PULSE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
        .iso_needed(iso_needed), .dwell(dwell),
        .func_ret_save(func[4]), .func_ret_restore(func[3]), .func_iso_en(func[2]),
        .func_pwr_on(func[1]), .func_scan_en(func[0]),
        .pwr_good(pwr_good), .shift_done(shift_done), .scan_in_data(sin), .scan_out_data(sout),
        .ret_save(ret_save), .ret_restore(ret_restore), .iso_en(iso_en), .pwr_on(pwr_on),
        .scan_en(scan_en), .shift_req(shift_req), .shift_out(shift_out), .busy(busy),
        .done(done), .fail(fail), .timeout_err(timeout_err));

    rtn_domain_model #(.DATA_W(DW), .PGD(PGD), .SHL(SHL), .RET_PULSE(1'b0)) u_dom (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .ret_save(ret_save),
        .ret_restore(ret_restore), .shift_req(shift_req), .shift_out(shift_out),
        .pg_block(pg_block), .ret_break(ret_break), .pattern(pattern),
        .pwr_good(pwr_good), .shift_done(shift_done), .scan_in_data(sin), .scan_out_data(sout));

    rtn_test_seq #(.DATA_W(DW), .CNT_W(CW), .TIMEOUT(TO), .RET_PULSE(1'b1)) u_dut_pulse (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .start(start),
        .iso_needed(iso_needed), .dwell(dwell),
        .func_ret_save(func[4]), .func_ret_restore(func[3]), .func_iso_en(func[2]),
        .func_pwr_on(func[1]), .func_scan_en(func[0]),
        .pwr_good(pwr_good_p), .shift_done(shift_done_p), .scan_in_data(sin_p),
        .scan_out_data(sout_p),
        .ret_save(ret_save_p), .ret_restore(ret_restore_p), .iso_en(iso_en_p),
        .pwr_on(pwr_on_p), .scan_en(scan_en_p), .shift_req(shift_req_p),
        .shift_out(shift_out_p), .busy(busy_p), .done(done_p), .fail(fail_p),
        .timeout_err(timeout_err_p));

    rtn_domain_model #(.DATA_W(DW), .PGD(PGD), .SHL(SHL), .RET_PULSE(1'b1)) u_dom_pulse (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on_p), .ret_save(ret_save_p),
        .ret_restore(ret_restore_p), .shift_req(shift_req_p), .shift_out(shift_out_p),
        .pg_block(pg_block), .ret_break(ret_break), .pattern(pattern),
        .pwr_good(pwr_good_p), .shift_done(shift_done_p), .scan_in_data(sin_p),
        .scan_out_data(sout_p));

    // Run-length trace of the level-mode outputs while busy.
    always @(negedge clk) begin
        if (busy) begin
            if (nt > 0 && tr_sig[nt-1] == {scan_en, shift_out, ret_save, ret_restore, iso_en, pwr_on})
                tr_len[nt-1]++;
            else if (nt < 32) begin
                tr_sig[nt] = {scan_en, shift_out, ret_save, ret_restore, iso_en, pwr_on};
                tr_len[nt] = 1;
                nt++;
            end
        end
        if (busy_p && ret_save_p) ps_cnt++;
        if (busy_p && ret_restore_p) pr_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void add_ex(input logic [5:0] s, input int l);
        ex_sig[ne] = s; ex_len[ne] = l; ne++;
    endfunction

    task automatic run_seq(input int d, input bit iso, input bit brk, input bit pgblk, input bit restart);
        bit ok;
        int pon;
        dwell = CW'(d); iso_needed = iso; ret_break = brk; pg_block = pgblk;
        pattern = DW'(8'h3C + d * 17 + (iso ? 64 : 0));
        pon = (d > PGD ? d : PGD) + 1;
        ne = 0;
        add_ex(6'b100001, SHL + 1);
        add_ex(6'b001001, d + 1);
        if (iso) add_ex(6'b001011, d + 1);
        add_ex({4'b0010, iso, 1'b0}, d + 1);
        if (pgblk) add_ex({4'b0010, iso, 1'b1}, TO + 1);
        else begin
            add_ex({4'b0010, iso, 1'b1}, pon);
            if (iso) add_ex(6'b001001, d + 1);
            add_ex(6'b000001, d + 1);
            add_ex(6'b110001, SHL + 1);
        end
        @(negedge clk);
        nt = 0; ps_cnt = 0; pr_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            repeat (4) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int k = 0; k < 300 && (busy || busy_p); k++) @(negedge clk);
        // R2 R3 R4 R5 R6 R7: step order and durations, with functional inputs opposing
        ok = (nt == ne);
        for (int i = 0; i < ne && ok; i++)
            if (tr_sig[i] != ex_sig[i] || tr_len[i] != ex_len[i]) ok = 0;
        chk(ok, "R3/R4/R5", $sformatf("trace d=%0d iso=%0d pg=%0d steps", d, iso, pgblk), nt, ne);
        for (int i = 0; i < ne && i < nt; i++)
            if (tr_sig[i] != ex_sig[i] || tr_len[i] != ex_len[i])
                chk(0, "R2/R5", $sformatf("step %0d sig*100+len", i),
                    int'(tr_sig[i]) * 100 + tr_len[i], int'(ex_sig[i]) * 100 + ex_len[i]);
        if (pgblk) chk(timeout_err && !done && !fail, "R7", "timeout flags {tmo,done,fail}",
                       {timeout_err, done, fail}, 3'b100);
        else chk(done && (fail == brk) && !timeout_err, "R9", "flags {tmo,done,fail}",
                 {timeout_err, done, fail}, {2'b01, brk});
        if (restart) chk(nt == ne, "R10", "start during run ignored", nt, ne);
        chk(!brk ? !fail : 1'b1, "R10", "fail cleared by new start", fail, 0);
        chk({ret_save, ret_restore, iso_en, pwr_on, scan_en} == func && !shift_req, "R9",
            "controls released after run", {ret_save, ret_restore, iso_en, pwr_on, scan_en}, func);
        chk(ps_cnt == 1 && pr_cnt == (pgblk ? 0 : 1), "R8", "pulse cycles save*10+restore",
            ps_cnt * 10 + pr_cnt, 10 + (pgblk ? 0 : 1));
        chk({timeout_err_p, done_p, fail_p} == {timeout_err, done, fail}, "R8",
            "pulse variant flags", {timeout_err_p, done_p, fail_p}, {timeout_err, done, fail});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fail && !timeout_err && !shift_req, "R1", "reset state",
            {busy, done, fail, timeout_err, shift_req}, 0);
        // R1: pass-through sweep with test mode low, start ignored
        for (int v = 0; v < 32; v++) begin
            func = 5'(v);
            start = v[0];
            #1;
            chk({ret_save, ret_restore, iso_en, pwr_on, scan_en} == 5'(v) && !shift_req, "R1",
                "pass-through", {ret_save, ret_restore, iso_en, pwr_on, scan_en}, v);
            @(negedge clk);
            chk(!busy, "R1", "start ignored without test mode", busy, 0);
        end
        start = 1'b0;
        func = 5'b11100;
        test_mode = 1'b1;
        // Sweep dwell, isolation need and retention fault
        for (int d = 0; d < 4; d++)
            for (int iso = 0; iso < 2; iso++)
                for (int brk = 0; brk < 2; brk++)
                    run_seq(d, iso[0], brk[0], 1'b0, (d == 2 && iso == 1 && brk == 0));
        // R7: power-good never arrives
        run_seq(1, 1'b0, 1'b0, 1'b1, 1'b0);
        run_seq(0, 1'b1, 1'b0, 1'b1, 1'b0);
        pg_block = 1'b0;
        // R11: abort during power-off
        dwell = CW'(3); iso_needed = 1'b1;
        @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
        for (int k = 0; k < 50 && pwr_on; k++) @(negedge clk);
        chk(busy && !pwr_on, "R11", "reached power-off", {busy, pwr_on}, 2'b10);
        test_mode = 1'b0;
        #1;
        chk({ret_save, ret_restore, iso_en, pwr_on, scan_en} == func, "R11",
            "controls follow functional at once", {ret_save, ret_restore, iso_en, pwr_on, scan_en}, func);
        @(negedge clk);
        chk(!busy && !done && !fail && !timeout_err, "R11", "idle after abort",
            {busy, done, fail, timeout_err}, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule